// File: doc/BRIEF.md
# Parallel Multi-Sample IQ Demodulator

This block turns a fast real-valued sample stream into baseband I and Q. The stream arrives as a wide word that holds several consecutive 8-bit samples in each clock. All lanes of the word are mixed in the same clock. Each lane gets its own local-oscillator phase, so the word behaves as if its samples had been processed one after another. A numerically controlled phase accumulator sets the oscillator frequency through a phase-increment input. A shared sine table gives the sine and cosine values for every lane.

The I products of one word are added into a single I value, and the Q products into a single Q value. This is a moving-average lowpass that keeps one I/Q pair per input word, which is a decimation equal to the lane count. The sum is built in a fully registered adder tree. The output strobe is delayed to match the tree exactly.

Top module: `iq_demod_par`

## Requirements
- R1: Each 8-bit input code c is read as offset binary. Its signed value is c − 128, so 0x80 counts as zero, 0xFF as +127 and 0x00 as −128.
- R2: Table entry a (0..255) is computed as follows. Let h = a mod 128 and p = h·(128 − h). The magnitude is (127·16·p + d/2) / d with d = 81920 − 4·p, using integer division. The result is negated when a ≥ 128. The sine value for address a is that entry. The cosine value is the entry at (a + 64) mod 256.
- R3: Lane k sits in bits [8k+7:8k], and lane 0 is the earliest sample. Its 16-bit phase is base + k·inc (mod 2^16). Bits [15:8] of that phase form its table address.
- R4: The base phase starts at 0. It advances by 16·inc (mod 2^16) for each accepted word. It does not change in any clock where in_valid is low, whatever phase_inc holds.
- R5: For each accepted word, out_i = Σ s_k·cos_k and out_q = −Σ s_k·sin_k over all 16 lanes, where s_k is the signed sample of lane k.
- R6: out_valid is high exactly 6 clocks after the clock edge that accepts a word, and it is never high otherwise. Back-to-back words give back-to-back results in order.
- R7: A synchronous reset clears out_valid, zeroes out_i and out_q and returns the base phase to 0. Words still in flight are dropped.
- R8: out_i and out_q are 20-bit two's complement and never wrap. A full-scale word (all 0xFF, or all 0x00) at phase 0 gives out_i = 258064 or −260096 respectively, with out_q = 0.
- R9: phase_inc is taken together with each word. A change between words applies to the lane phases of the new word and to the base step that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word strobe for in_samples |
| in_samples | input | 128 | Sixteen 8-bit offset-binary samples, lane 0 in the low byte |
| phase_inc | input | 16 | Oscillator phase step per sample |
| out_valid | output | 1 | Strobe for out_i and out_q |
| out_i | output | 20 | In-phase sum, signed |
| out_q | output | 20 | Quadrature sum, signed |

## Verification
The bench targets lane ordering with one non-midscale lane and a large increment. A design that reversed the lanes or ignored the k·inc offset would put that sample at the wrong phase, and I/Q would come out wrong. Idle gaps are sent while phase_inc keeps changing. A base that advanced on idle clocks, or stepped by inc rather than 16·inc, would shift the phase of every later word. Full-scale words at known phases check the sign handling and the width. A wrong offset-binary conversion or a narrow adder would flip the sign or wrap. A reset issued while words are in flight must drop them and restart the phase at zero. The bench also times every result to the exact clock, so a tree stage missing from the valid delay would show up as a late or early strobe.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
    localparam int LUT_AW   = 8;
    localparam int LUT_W    = 8;
    localparam int LUT_N    = 1 << LUT_AW;
    localparam int LUT_HALF = LUT_N / 2;
    localparam int LUT_QTR  = LUT_N / 4;
    localparam int LUT_AMP  = (1 << (LUT_W - 1)) - 1;

    typedef logic signed [LUT_W-1:0] lut_word_t;
    typedef lut_word_t lut_tab_t [LUT_N];

    // rational sine approximation over a half cycle, odd symmetry for the rest
    function automatic lut_word_t sine_point(input int addr);
        int h, p, d, v;
        h = addr % LUT_HALF;
        p = h * (LUT_HALF - h);
        d = 5 * LUT_HALF * LUT_HALF - 4 * p;
        v = (LUT_AMP * 16 * p + d / 2) / d;
        if (addr >= LUT_HALF) v = -v;
        return lut_word_t'(v);
    endfunction

    function automatic lut_tab_t build_sine();
        lut_tab_t t;
        for (int a = 0; a < LUT_N; a++) t[a] = sine_point(a);
        return t;
    endfunction
endpackage

// File: rtl/iqd_phase_gen.sv
module iqd_phase_gen
    import iqd_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int PHASE_W = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           advance,
    input  logic [PHASE_W-1:0]             inc,
    output logic [LANES-1:0][LUT_AW-1:0]   lane_addr,
    output logic [PHASE_W-1:0]             base
);
    localparam int SHIFT = PHASE_W - LUT_AW;

    typedef struct packed {
        logic [PHASE_W-1:0] base;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) st_d.base = st_q.base + PHASE_W'(LANES) * inc;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_addr[k] = LUT_AW'((st_q.base + PHASE_W'(k) * inc) >> SHIFT);
    end

    assign base = st_q.base;
endmodule

// File: rtl/iqd_lane_mixer.sv
module iqd_lane_mixer
    import iqd_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int PROD_W   = SAMPLE_W + LUT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SAMPLE_W-1:0]      sample,
    input  logic [LUT_AW-1:0]        addr,
    output logic signed [PROD_W-1:0] prod_i,
    output logic signed [PROD_W-1:0] prod_q
);
    localparam lut_tab_t SINE = build_sine();

    typedef struct {
        logic signed [SAMPLE_W-1:0] smp;
        lut_word_t                  sin_v;
        lut_word_t                  cos_v;
        logic signed [PROD_W-1:0]   pi;
        logic signed [PROD_W-1:0]   pq;
    } mix_st_t;

    mix_st_t st_d, st_q;
    logic [LUT_AW-1:0] cos_addr;

    always_comb begin
        cos_addr  = addr + LUT_AW'(LUT_QTR);
        st_d.smp  = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]};
        st_d.sin_v = SINE[addr];
        st_d.cos_v = SINE[cos_addr];
        st_d.pi   = PROD_W'(st_q.smp) * PROD_W'(st_q.cos_v);
        st_d.pq   = -(PROD_W'(st_q.smp) * PROD_W'(st_q.sin_v));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{default: '0};
        else     st_q <= st_d;
    end

    assign prod_i = st_q.pi;
    assign prod_q = st_q.pq;
endmodule

// File: rtl/iqd_sum_tree.sv
module iqd_sum_tree #(
    parameter int LANES = 16,
    parameter int IN_W  = 16,
    parameter int OUT_W = IN_W + $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LANES-1:0][IN_W-1:0]   din,
    output logic signed [OUT_W-1:0]      dout
);
    localparam int LEVELS = $clog2(LANES);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int CNT = LANES >> l;
        logic signed [OUT_W-1:0] node_q [CNT];

        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_ext
                assign node_q[j] = OUT_W'($signed(din[j]));
            end
        end else begin : g_add
            logic signed [OUT_W-1:0] node_d [CNT];

            always_comb begin
                for (int j = 0; j < CNT; j++)
                    node_d[j] = g_lvl[l-1].node_q[2*j] + g_lvl[l-1].node_q[2*j+1];
            end

            always_ff @(posedge clk) begin
                for (int j = 0; j < CNT; j++)
                    node_q[j] <= rst ? '0 : node_d[j];
            end
        end
    end

    assign dout = g_lvl[LEVELS].node_q[0];
endmodule

// File: rtl/iq_demod_par.sv
module iq_demod_par
    import iqd_pkg::*;
#(
    parameter int LANES    = 16,
    parameter int SAMPLE_W = 8,
    parameter int PHASE_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [LANES*SAMPLE_W-1:0]       in_samples,
    input  logic [PHASE_W-1:0]              phase_inc,
    output logic                            out_valid,
    output logic signed [SAMPLE_W+LUT_W+$clog2(LANES)-1:0] out_i,
    output logic signed [SAMPLE_W+LUT_W+$clog2(LANES)-1:0] out_q
);
    localparam int PROD_W = SAMPLE_W + LUT_W;
    localparam int LEVELS = $clog2(LANES);
    localparam int SUM_W  = PROD_W + LEVELS;
    localparam int LAT    = 2 + LEVELS;

    logic [LANES-1:0][LUT_AW-1:0] lane_addr;
    logic [PHASE_W-1:0]           phase_base;
    logic [LANES-1:0][PROD_W-1:0] prod_i_all;
    logic [LANES-1:0][PROD_W-1:0] prod_q_all;

    iqd_phase_gen #(.LANES(LANES), .PHASE_W(PHASE_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .advance   (in_valid),
        .inc       (phase_inc),
        .lane_addr (lane_addr),
        .base      (phase_base)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_mix
        iqd_lane_mixer #(.SAMPLE_W(SAMPLE_W), .PROD_W(PROD_W)) u_mix (
            .clk    (clk),
            .rst    (rst),
            .sample (in_samples[k*SAMPLE_W +: SAMPLE_W]),
            .addr   (lane_addr[k]),
            .prod_i (prod_i_all[k]),
            .prod_q (prod_q_all[k])
        );
    end

    iqd_sum_tree #(.LANES(LANES), .IN_W(PROD_W), .OUT_W(SUM_W)) u_sum_i (
        .clk  (clk),
        .rst  (rst),
        .din  (prod_i_all),
        .dout (out_i)
    );

    iqd_sum_tree #(.LANES(LANES), .IN_W(PROD_W), .OUT_W(SUM_W)) u_sum_q (
        .clk  (clk),
        .rst  (rst),
        .din  (prod_q_all),
        .dout (out_q)
    );

    typedef struct packed {
        logic [LAT-1:0] vld;
    } vld_st_t;

    vld_st_t vs_d, vs_q;

    always_comb begin
        vs_d.vld = {vs_q.vld[LAT-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        if (rst) vs_q <= '0;
        else     vs_q <= vs_d;
    end

    assign out_valid = vs_q.vld[LAT-1];
endmodule

// File: rtl/iq_demod_par_chk.sv
module iq_demod_par_chk #(
    parameter int LANES    = 16,
    parameter int SAMPLE_W = 8,
    parameter int PHASE_W  = 16,
    parameter int SUM_W    = 20
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [SUM_W-1:0] out_i,
    input logic signed [SUM_W-1:0] out_q,
    input logic [PHASE_W-1:0]      base
);
    localparam int LAT   = 2 + $clog2(LANES);
    localparam int BOUND = LANES * (1 << (SAMPLE_W - 1)) * 127;

    // R6: a result strobe always traces back to an accepted word
    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, LAT));

    // R7: the clock after reset shows an empty pipe and a zero phase
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && base == '0));

    // R4: no accepted word, no phase movement
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(base));

    // R8: sums stay inside the representable full-scale range
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_i >= -BOUND && out_i <= BOUND &&
                       out_q >= -BOUND && out_q <= BOUND));
endmodule

bind iq_demod_par iq_demod_par_chk #(
    .LANES(LANES), .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .SUM_W(SUM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .base      (phase_base)
);

// File: tb/iq_demod_par_test.sv
module iq_demod_par_test;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [127:0]       in_samples = '0;
    logic [15:0]        phase_inc = '0;
    logic               out_valid;
    logic signed [19:0] out_i;
    logic signed [19:0] out_q;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [15:0] tb_base = '0;

    typedef struct {
        int    ei;
        int    eq;
        int    due;
        string req;
    } exp_t;
    exp_t pend[$];

    iq_demod_par uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
        .phase_inc(phase_inc), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sin_ref(input int a);
        int h, p, d, v;
        h = a % 128;
        p = h * (128 - h);
        d = 81920 - 4 * p;
        v = (127 * 16 * p + d / 2) / d;
        return (a >= 128) ? -v : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // result monitor, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (out_valid) begin
            if (pend.size() == 0) begin
                check("R6 unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = pend.pop_front();
                check({e.req, " R6 timing"}, cyc, e.due);
                check({e.req, " R5 I"}, int'(out_i), e.ei);
                check({e.req, " R5 Q"}, int'(out_q), e.eq);
            end
        end
    end

    task automatic send_word(input logic [127:0] w, input logic [15:0] inc, input string req);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        in_samples = w;
        phase_inc  = inc;
        e.ei = 0; e.eq = 0; e.req = req; e.due = cyc + 6;
        for (int k = 0; k < 16; k++) begin
            int s, a;
            logic [15:0] ph;
            s  = int'(w[8*k +: 8]) - 128;
            ph = tb_base + 16'(k) * inc;
            a  = int'(ph[15:8]);
            e.ei += s * sin_ref((a + 64) % 256);
            e.eq -= s * sin_ref(a);
        end
        tb_base = tb_base + 16'(16) * inc;
        pend.push_back(e);
    endtask

    task automatic idle(input int n, input logic [15:0] inc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            phase_inc = inc;
            in_samples = {8{16'hA55A}};
        end
    endtask

    task automatic drain(input string req);
        idle(9, phase_inc);
        check({req, " all results delivered"}, pend.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        pend.delete();
        tb_base = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [127:0] fill(input logic [7:0] v);
        logic [127:0] w;
        for (int k = 0; k < 16; k++) w[8*k +: 8] = v;
        return w;
    endfunction

    function automatic logic [127:0] pattern(input int seed);
        logic [127:0] w;
        for (int k = 0; k < 16; k++) w[8*k +: 8] = 8'((k * 37 + seed * 11 + 5) & 255);
        return w;
    endfunction

    task automatic test_reset_state();
        do_reset();
        check("R7 out_valid after reset", int'(out_valid), 0);
        check("R7 out_i after reset", int'(out_i), 0);
        check("R7 out_q after reset", int'(out_q), 0);
    endtask

    task automatic test_full_scale();
        // phase 0, inc 0: cos = 127, sin = 0 on every lane
        send_word(fill(8'hFF), 16'h0000, "R8 +full");
        send_word(fill(8'h00), 16'h0000, "R8 -full R1");
        send_word(fill(8'h80), 16'h0000, "R1 midscale");
        drain("R8");
    endtask

    task automatic test_tone();
        for (int n = 0; n < 8; n++) send_word(pattern(n), 16'h0B40, "R2 R3 tone");
        send_word(fill(8'hFF), 16'h1000, "R2 quarter steps");
        drain("R3");
    endtask

    task automatic test_lane_order();
        for (int k = 0; k < 16; k += 5) begin
            logic [127:0] w;
            w = fill(8'h80);
            w[8*k +: 8] = 8'hF0;
            send_word(w, 16'h1300, "R3 lane order");
        end
        drain("R3");
    endtask

    task automatic test_gaps();
        send_word(pattern(3), 16'h0321, "R4 before gap");
        idle(3, 16'h7777);
        send_word(pattern(4), 16'h0321, "R4 after gap");
        idle(1, 16'hFFFF);
        send_word(pattern(5), 16'h0321, "R4 after short gap");
        drain("R4");
    endtask

    task automatic test_inc_change();
        send_word(pattern(7), 16'h0100, "R9 inc a");
        send_word(pattern(8), 16'h2A00, "R9 inc b");
        send_word(pattern(9), 16'hF123, "R9 inc c");
        send_word(pattern(10), 16'h0010, "R9 inc d");
        drain("R9");
    endtask

    task automatic test_reset_flight();
        send_word(pattern(1), 16'h0444, "R7 in flight");
        send_word(pattern(2), 16'h0444, "R7 in flight");
        do_reset();
        idle(8, 16'h0444);
        check("R7 flushed words produce no strobe", int'(out_valid), 0);
        // phase restarts at zero: full-scale word gives the phase-0 result
        send_word(fill(8'hFF), 16'h0000, "R7 phase restart");
        drain("R7");
    endtask

    initial begin
        test_reset_state();
        test_full_scale();
        test_tone();
        test_lane_order();
        test_gaps();
        test_inc_change();
        test_reset_flight();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule